// File: doc/BRIEF.md
# Streaming SPI Master Byte Engine

This block is a full-duplex SPI master that moves fixed-width frames (eight bits by default). A host reaches it through a small register port with three registers: a data register, a status register and an interrupt-enable register. Writing the data register queues one byte in a single-entry transmit buffer. The buffer feeds a shift register. The shift register drives the serial clock and data-out, and it samples data-in at the same time. When a frame completes, the assembled byte goes into a single-entry receive buffer.

Reception only happens as a side effect of transmission. To read a byte, the host writes a byte, which may be a dummy. If the host refills the transmit buffer before the current frame finishes, the next frame starts on the same system clock cycle as the final falling edge. The serial clock therefore keeps running with no extra low time between frames. Three level interrupt requests are available: transmit buffer empty, receive buffer full and transfer end. Slave select is not part of the block; the host drives it from a general-purpose pin.

Top module: `spi_stream_master`

## Requirements
- R1: After reset, sclk and mosi are 0, all three interrupt outputs are 0, the status register reads 0x01 and the enable register reads 0x00.
- R2: A frame gives exactly DATA_W rising edges on sclk. Each half period lasts CLK_DIV/2 system clocks, so rising edges within a frame are CLK_DIV clocks apart. sclk stays low whenever no frame is active.
- R3: Data goes out MSB first in mode 0. mosi changes only when a frame is loaded or on a falling sclk edge. miso is sampled on each rising sclk edge.
- R4: At the final falling edge of a frame, the received byte is written to the receive buffer and status bit 1 (receive full) is set. A read of address 0 returns that byte on the next cycle and clears bit 1.
- R5: Writing address 0 fills the transmit buffer. The buffer moves into the shifter at the start of a frame, which sets status bit 0 (transmit empty). The host may write the next byte while a frame is still shifting.
- R6: If the transmit buffer holds a byte when a frame ends, the next frame starts at once. The rising-edge spacing across the frame boundary stays CLK_DIV clocks.
- R7: When a frame completes while receive full is already set, the new byte replaces the old one. No other status bit changes.
- R8: Status bit 2 (transfer end) is set when a frame ends with the transmit buffer empty. Writing 1 to bit 2 of address 1 clears it, and writing 0 there has no effect.
- R9: The enable register is at address 2. Bit 0 enables transmit empty, bit 1 enables receive full and bit 2 enables transfer end. Each interrupt output equals its status flag AND its enable bit.
- R10: Status bit 3 (busy) is 1 while a frame is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register address: 0 data, 1 status, 2 enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears next cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq_txe | output | 1 | Transmit buffer empty request |
| irq_rxf | output | 1 | Receive buffer full request |
| irq_end | output | 1 | Transfer end request |

## Verification
A corrupted bit counter shows up on sclk within the same frame, as a wrong pulse count or a missing falling edge. A slave-side monitor that logs every rising edge detects this. A wrong shift register or sample register shows up as a wrong bit on mosi, which the monitor compares on each rising edge, or as a wrong byte returned by the next data read. Stale buffer flags appear in the status word and on the interrupt pins one cycle after the event that should have changed them. When a frame chaining decision goes wrong, the rising-edge spacing across the frame boundary stretches, so the streaming test checks every interval.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_IEN  = 2'd2;

  localparam int ST_TXE  = 0;
  localparam int ST_RXF  = 1;
  localparam int ST_END  = 2;
  localparam int ST_BUSY = 3;

  typedef struct packed {
    logic fin;
    logic rxf;
    logic txe;
  } irq_vec_t;
endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = (CLK_DIV / 2 < 1) ? 1 : CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          edge_w;

  assign edge_w = run_i && (cnt_q == CW'(HALF - 1));
  assign rise_o = edge_w && !sclk_q;
  assign fall_o = edge_w && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (edge_w) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              miso_i,
  input  logic              pend_i,
  input  logic [DATA_W-1:0] pend_byte_i,
  output logic              take_o,
  output logic              done_o,
  output logic [DATA_W-1:0] done_byte_o,
  output logic              idle_end_o,
  output logic              busy_o,
  output logic              mosi_o
);
  localparam int BW = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sh_q;
  logic [BW-1:0]     cnt_q;
  logic              busy_q;
  logic              smp_q;
  logic              start_w;
  logic              last_fall_w;

  always_comb begin
    start_w     = !busy_q && pend_i;
    last_fall_w = busy_q && fall_i && (cnt_q == BW'(DATA_W - 1));
    take_o      = start_w || (last_fall_w && pend_i);
    done_o      = last_fall_w;
    done_byte_o = {sh_q[DATA_W-2:0], smp_q};
    idle_end_o  = last_fall_w && !pend_i;
  end

  assign busy_o = busy_q;
  assign mosi_o = sh_q[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      smp_q  <= 1'b0;
    end else begin
      if (busy_q && rise_i) smp_q <= miso_i;
      if (take_o) begin
        sh_q   <= pend_byte_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (last_fall_w) begin
        busy_q <= 1'b0;
      end else if (busy_q && fall_i) begin
        sh_q  <= {sh_q[DATA_W-2:0], smp_q};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_MOSI_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(mosi_o) |-> $past(take_o || fall_i)); // R3
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_stream_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              take_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] done_byte_i,
  input  logic              idle_end_i,
  input  logic              busy_i,
  output logic              pend_o,
  output logic [DATA_W-1:0] pend_byte_o,
  output logic              irq_txe_o,
  output logic              irq_rxf_o,
  output logic              irq_end_o
);
  logic [DATA_W-1:0] txb_q, txb_n, rxb_q, rxb_n, rdata_q, stat_w;
  logic              full_q, full_n, rxf_q, rxf_n, end_q, end_n;
  irq_vec_t          ien_q, ien_n;
  logic              irq_txe_q, irq_rxf_q, irq_end_q;
  logic              wr_data, rd_data, wr_stat, wr_ien;

  always_comb begin
    wr_data = wr_i && (sel_i == SEL_DATA);
    rd_data = rd_i && (sel_i == SEL_DATA);
    wr_stat = wr_i && (sel_i == SEL_STAT);
    wr_ien  = wr_i && (sel_i == SEL_IEN);

    full_n = full_q;
    txb_n  = txb_q;
    if (take_i)  full_n = 1'b0;
    if (wr_data) begin
      full_n = 1'b1;
      txb_n  = wdata_i;
    end

    rxf_n = rxf_q;
    rxb_n = rxb_q;
    if (rd_data) rxf_n = 1'b0;
    if (done_i) begin
      rxf_n = 1'b1;
      rxb_n = done_byte_i;
    end

    end_n = end_q;
    if (wr_stat && wdata_i[ST_END]) end_n = 1'b0;
    if (idle_end_i) end_n = 1'b1;

    ien_n = ien_q;
    if (wr_ien) ien_n = irq_vec_t'(wdata_i[2:0]);

    stat_w          = '0;
    stat_w[ST_TXE]  = !full_q;
    stat_w[ST_RXF]  = rxf_q;
    stat_w[ST_END]  = end_q;
    stat_w[ST_BUSY] = busy_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txb_q     <= '0;
      rxb_q     <= '0;
      full_q    <= 1'b0;
      rxf_q     <= 1'b0;
      end_q     <= 1'b0;
      ien_q     <= '0;
      rdata_q   <= '0;
      irq_txe_q <= 1'b0;
      irq_rxf_q <= 1'b0;
      irq_end_q <= 1'b0;
    end else begin
      txb_q     <= txb_n;
      rxb_q     <= rxb_n;
      full_q    <= full_n;
      rxf_q     <= rxf_n;
      end_q     <= end_n;
      ien_q     <= ien_n;
      irq_txe_q <= !full_n && ien_n.txe;
      irq_rxf_q <= rxf_n && ien_n.rxf;
      irq_end_q <= end_n && ien_n.fin;
      if (rd_i) begin
        case (sel_i)
          SEL_DATA: rdata_q <= rxb_q;
          SEL_STAT: rdata_q <= stat_w;
          SEL_IEN:  rdata_q <= DATA_W'(ien_q);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o     = rdata_q;
  assign pend_o      = full_q;
  assign pend_byte_o = txb_q;
  assign irq_txe_o   = irq_txe_q;
  assign irq_rxf_o   = irq_rxf_q;
  assign irq_end_o   = irq_end_q;

  AST_RXF_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done_i |=> rxf_q); // R4
  AST_LOAD_FREES_BUF: assert property (@(posedge clk) disable iff (rst)
    (take_i && !wr_data) |=> !full_q); // R5
  AST_END_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(end_q) |-> !busy_i); // R8
  AST_RXF_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_rxf_o) |-> $past(done_i || wr_ien)); // R9
endmodule

// File: rtl/spi_stream_master.sv
module spi_stream_master #(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              irq_txe,
  output logic              irq_rxf,
  output logic              irq_end
);
  localparam int PCW = $clog2(DATA_W) + 1;

  logic              rise_w, fall_w, busy_w, take_w, done_w, idle_end_w, pend_w;
  logic [DATA_W-1:0] done_byte_w, pend_byte_w;

  spi_sclk_gen #(.CLK_DIV(CLK_DIV)) u_gen (
    .clk(clk), .rst(rst), .run_i(busy_w),
    .sclk_o(sclk), .rise_o(rise_w), .fall_o(fall_w)
  );

  spi_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .rise_i(rise_w), .fall_i(fall_w), .miso_i(miso),
    .pend_i(pend_w), .pend_byte_i(pend_byte_w), .take_o(take_w),
    .done_o(done_w), .done_byte_o(done_byte_w), .idle_end_o(idle_end_w),
    .busy_o(busy_w), .mosi_o(mosi)
  );

  spi_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .sel_i(reg_sel), .wr_i(reg_wr), .rd_i(reg_rd),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .take_i(take_w),
    .done_i(done_w), .done_byte_i(done_byte_w), .idle_end_i(idle_end_w),
    .busy_i(busy_w), .pend_o(pend_w), .pend_byte_o(pend_byte_w),
    .irq_txe_o(irq_txe), .irq_rxf_o(irq_rxf), .irq_end_o(irq_end)
  );

  logic [PCW-1:0] pulse_cnt_q;
  always_ff @(posedge clk) begin
    if (rst || take_w) pulse_cnt_q <= '0;
    else if (rise_w)   pulse_cnt_q <= pulse_cnt_q + 1'b1;
  end

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
    !busy_w |-> !sclk); // R2
  AST_PULSES_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
    done_w |-> (pulse_cnt_q == PCW'(DATA_W))); // R2
endmodule

// File: tb/tb_spi_stream_master.sv
`timescale 1ns/1ps
module tb_spi_stream_master;
  localparam int W   = 8;
  localparam int DIV = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   reg_sel = '0;
  logic         reg_wr = 1'b0;
  logic         reg_rd = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         sclk, mosi, irq_txe, irq_rxf, irq_end;
  logic         miso = 1'b0;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [W-1:0] exp_mosi_q[$];
  logic [W-1:0] slave_q[$];
  logic [W-1:0] exp_rx_q[$];
  time          rise_t[$];
  int           ridx = 0;
  int           rises = 0;
  logic [W-1:0] cap = '0;

  spi_stream_master #(.DATA_W(W), .CLK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .irq_txe(irq_txe), .irq_rxf(irq_rxf), .irq_end(irq_end)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic update_miso();
    if (slave_q.size() > 0) miso = slave_q[0][W-1-ridx];
    else miso = 1'b0;
  endtask

  // Monitor: slave model and scoreboard for outgoing bits
  always @(posedge sclk) begin
    rise_t.push_back($time);
    rises++;
    cap = {cap[W-2:0], mosi};
    ridx++;
    if (ridx == W) begin
      ridx = 0;
      if (exp_mosi_q.size() > 0) begin
        logic [W-1:0] e;
        e = exp_mosi_q.pop_front();
        check(cap == e, "R3 mosi frame MSB-first", 32'(cap), 32'(e));
      end else begin
        check(1'b0, "R3 unexpected frame", 32'(cap), 0);
      end
      if (slave_q.size() > 0) exp_rx_q.push_back(slave_q.pop_front());
      else exp_rx_q.push_back('0);
    end
    update_miso();
  end

  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
    reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
    reg_sel = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // Driver: queue expectations, then write the byte
  task automatic send(input logic [W-1:0] tx, input logic [W-1:0] reply);
    exp_mosi_q.push_back(tx);
    slave_q.push_back(reply);
    if (ridx == 0 && slave_q.size() == 1) update_miso();
    bus_write(2'd0, tx);
  endtask

  task automatic read_rx(input string req);
    logic [W-1:0] d;
    logic [W-1:0] e;
    bus_read(2'd0, d);
    e = (exp_rx_q.size() > 0) ? exp_rx_q.pop_front() : 'x;
    check(d === e, req, 32'(d), 32'(e));
  endtask

  task automatic wait_stat(input int b);
    logic [W-1:0] s;
    for (int i = 0; i < 400; i++) begin
      bus_read(2'd1, s);
      if (s[b]) return;
    end
    check(1'b0, "wait status bit", 0, 32'(b));
  endtask

  task automatic check_spacing(input string req);
    bit ok = 1;
    for (int i = 1; i < rise_t.size(); i++)
      if (rise_t[i] - rise_t[i-1] != time'(DIV * 8)) ok = 0;
    check(ok, req, 32'(rise_t.size()), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(sclk == 0 && mosi == 0, "R1 sclk/mosi low", {sclk, mosi}, 0);
    check({irq_txe, irq_rxf, irq_end} == 0, "R1 irqs low",
          {irq_txe, irq_rxf, irq_end}, 0);
    bus_read(2'd1, d); check(d == 8'h01, "R1 status", d, 8'h01);
    bus_read(2'd2, d); check(d == 8'h00, "R1 enable", d, 8'h00);

    // Single frame: R2 R3 R4 R5 R10
    rise_t.delete(); rises = 0;
    send(8'hA5, 8'h3C);
    @(negedge clk);
    bus_read(2'd1, d); check(d == 8'h09, "R5/R10 loaded and busy", d, 8'h09);
    wait_stat(1);
    check(rises == W, "R2 pulse count", rises, W);
    check_spacing("R2 half period");
    check(sclk == 0, "R2 sclk idle low", sclk, 0);
    bus_read(2'd1, d); check(d == 8'h07, "R4/R8 rx full and end", d, 8'h07);
    read_rx("R4 received byte");
    bus_read(2'd1, d); check(d == 8'h05, "R4 read clears full", d, 8'h05);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, d); check(d == 8'h05, "R8 write 0 no effect", d, 8'h05);
    bus_write(2'd1, 8'h04);
    bus_read(2'd1, d); check(d == 8'h01, "R8 write 1 clears", d, 8'h01);

    // Streaming: R6
    rise_t.delete(); rises = 0;
    send(8'h81, 8'hE7);
    send(8'h5A, 8'h18);
    wait_stat(1); read_rx("R6 stream byte 0");
    send(8'hC3, 8'h66);
    wait_stat(1); read_rx("R6 stream byte 1");
    wait_stat(1); read_rx("R6 stream byte 2");
    wait_stat(2);
    check(rises == 3 * W, "R6 stream pulses", rises, 3 * W);
    check_spacing("R6 gap-free spacing");
    bus_write(2'd1, 8'h04);

    // Overrun: R7
    send(8'h0F, 8'h11);
    send(8'hF0, 8'h22);
    wait_stat(2);
    bus_read(2'd1, d); check(d == 8'h07, "R7 status only full/end", d, 8'h07);
    void'(exp_rx_q.pop_front());
    read_rx("R7 newest byte kept");
    bus_write(2'd1, 8'h04);

    // Interrupts: R9
    bus_write(2'd2, 8'h07);
    bus_read(2'd2, d); check(d == 8'h07, "R9 enable readback", d, 8'h07);
    check({irq_end, irq_rxf, irq_txe} == 3'b001, "R9 only txe irq",
          {irq_end, irq_rxf, irq_txe}, 3'b001);
    send(8'h99, 8'hB4);
    @(negedge clk);
    check(irq_txe == 1, "R9 txe irq after load", irq_txe, 1);
    wait_stat(2);
    @(negedge clk);
    check({irq_end, irq_rxf, irq_txe} == 3'b111, "R9 all irqs",
          {irq_end, irq_rxf, irq_txe}, 3'b111);
    bus_write(2'd2, 8'h00);
    check({irq_end, irq_rxf, irq_txe} == 3'b000, "R9 masked",
          {irq_end, irq_rxf, irq_txe}, 0);
    bus_write(2'd2, 8'h02);
    check({irq_end, irq_rxf, irq_txe} == 3'b010, "R9 rxf only",
          {irq_end, irq_rxf, irq_txe}, 3'b010);
    read_rx("R4 irq frame byte");
    @(negedge clk);
    check(irq_rxf == 0, "R9 rxf irq drops on read", irq_rxf, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule